// File: doc/BRIEF.md
# Floating normalize-and-round unit

This block turns a raw 72-bit two's-complement fraction and a working exponent into a finished floating-point word, or into a two-word long result. Arithmetic stages upstream place their unnormalized sum, product or quotient on `frac_i`. They give the exponent that goes with that fraction, pick a store mode, and pulse `start_i`. The unit then runs a few dispatch steps, one per clock. Each step looks at where the leading one sits and applies one small correction. When the leading one reaches bit 62, the unit rounds or truncates, inserts the exponent, restores the sign, and pulses `done_o` with the result words.

A result word has the sign in bit 35, the low eight bits of the exponent in bits 34:27, and a 27-bit fraction in bits 26:0. The word is built in positive form. When the input was negative, the whole 36-bit word is then negated. The exponent is carried internally as a 10-bit two's-complement value. Exponent overflow is not flagged. A zero result is reported on `zero_o`.

Top module: `fnr_unit`

## Requirements
- R1: After reset, `done_o` and `zero_o` are low and `hi_o` and `lo_o` are zero.
- R2: `start_i` is accepted only while the unit is idle. A `start_i` raised during a conversion has no effect on that conversion's result or timing.
- R3: Each cycle after the start edge performs one dispatch step. If the conversion takes N steps (the last step is the one that finds bit 62 set or the fraction zero), `done_o` is high for exactly the one cycle that follows the (N+1)-th clock edge after the start edge.
- R4: When bit 71 of the fraction is set and no negation has yet been done, a step replaces the fraction with its 72-bit two's complement and marks the result negative. Later steps treat the fraction as unsigned. Each final word of a negative result is the 36-bit two's complement of its positive form.
- R5: When the leading one is in bits 71..63, a step shifts the fraction right by two and adds 2 to the exponent.
- R6: When the leading one is at bit 61, 60 or 59, a step shifts left by 1, 2 or 3 and subtracts the same amount from the exponent. When it is in bits 58..36, a step shifts left by 4 and subtracts 4.
- R7: When bits 71..36 are zero and bits 35..0 are not, a step moves the low 36 bits into the high half, then shifts right by two, so the exponent drops by 34 in total.
- R8: An all-zero fraction ends the conversion in one step. `zero_o` goes high and both words are zero, with no exponent.
- R9: Once normalized, the positive high word is {0, exponent[7:0], fraction bits 62..36}. Its bit 26 is always one for a nonzero result.
- R10: Mode 00 (round) adds fraction bit 35 to the 27-bit high fraction. A carry out of that fraction shifts it right by one and adds 1 to the exponent.
- R11: Mode 01 (truncate) discards bits 35..0. For a negative result, the magnitude is raised by one if any discarded bit is set, so the result rounds toward minus infinity. A resulting carry renormalizes as in R10.
- R12: Mode 1x (long) truncates the high word. The low word is {0, (exponent-27)[7:0], fraction bits 35..9}. It is forced to zero when exponent-27 is negative or those 27 bits are zero, and it is negated separately when the result is negative. In modes 00 and 01, `lo_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (sampled when idle) |
| frac_i | input | 72 | Two's-complement fraction, target leading-one bit 62 |
| exp_i | input | 10 | Working exponent, two's complement |
| mode_i | input | 2 | 00 round, 01 truncate, 1x long |
| done_o | output | 1 | One-cycle result strobe |
| zero_o | output | 1 | Result was zero |
| hi_o | output | 36 | High result word |
| lo_o | output | 36 | Low result word (long mode) |

## Verification
Any wrong dispatch choice changes how many steps a conversion takes. Because the cycle on which `done_o` rises is fixed by the step count, a misrouted shift or a repeated negation usually shows up as a `done_o` that is early or late. A wrong shift amount or exponent adjustment that leaves the count unchanged shows up in the exponent field of `hi_o` in the strobe cycle of that same conversion. Rounding, masking and long-mode faults appear only in the fraction bits or in `lo_o`, and only in that strobe cycle. For that reason, every conversion is compared against a reference on both timing and content.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_PACK = 2'd2
  } fnr_state_e;

  localparam logic [1:0] MODE_ROUND = 2'b00;
  localparam logic [1:0] MODE_TRUNC = 2'b01;
endpackage

// File: rtl/fnr_step.sv
module fnr_step #(
  parameter int WORD_W = 36,
  parameter int EXP_W  = 8,
  parameter int WEXP_W = 10
) (
  input  logic [2*WORD_W-1:0] frac_i,
  input  logic [WEXP_W-1:0]   exp_i,
  input  logic                neg_i,
  output logic [2*WORD_W-1:0] frac_o,
  output logic [WEXP_W-1:0]   exp_o,
  output logic                neg_o,
  output logic                fin_o
);
  localparam int DW  = 2*WORD_W;
  localparam int TGT = DW-2-EXP_W;

  always_comb begin
    frac_o = frac_i;
    exp_o  = exp_i;
    neg_o  = neg_i;
    fin_o  = 1'b0;
    if (frac_i == '0) begin
      fin_o = 1'b1;
    end else if (!neg_i && frac_i[DW-1]) begin
      frac_o = -frac_i;
      neg_o  = 1'b1;
    end else if (frac_i[DW-1:WORD_W] == '0) begin
      // jump the low word up, then back off by two
      frac_o = {frac_i[WORD_W-1:0], {WORD_W{1'b0}}} >> 2;
      exp_o  = exp_i - WEXP_W'(WORD_W-2);
    end else if (|frac_i[DW-1:TGT+1]) begin
      frac_o = frac_i >> 2;
      exp_o  = exp_i + WEXP_W'(2);
    end else if (frac_i[TGT]) begin
      fin_o = 1'b1;
    end else if (frac_i[TGT-1]) begin
      frac_o = frac_i << 1;
      exp_o  = exp_i - WEXP_W'(1);
    end else if (frac_i[TGT-2]) begin
      frac_o = frac_i << 2;
      exp_o  = exp_i - WEXP_W'(2);
    end else if (frac_i[TGT-3]) begin
      frac_o = frac_i << 3;
      exp_o  = exp_i - WEXP_W'(3);
    end else begin
      frac_o = frac_i << 4;
      exp_o  = exp_i - WEXP_W'(4);
    end
  end
endmodule

// File: rtl/fnr_pack.sv
module fnr_pack
  import fnr_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int EXP_W  = 8,
  parameter int WEXP_W = 10
) (
  input  logic [2*WORD_W-1:0] frac_i,
  input  logic [WEXP_W-1:0]   exp_i,
  input  logic                neg_i,
  input  logic [1:0]          mode_i,
  output logic [WORD_W-1:0]   hi_o,
  output logic [WORD_W-1:0]   lo_o,
  output logic                zero_o
);
  localparam int FRAC_W = WORD_W-1-EXP_W;
  localparam int TGT    = 2*WORD_W-2-EXP_W;

  logic [FRAC_W-1:0] hf, lf, f;
  logic [WORD_W-1:0] rest, hw, lw;
  logic [FRAC_W:0]   sum;
  logic [EXP_W-1:0]  e8;
  logic [WEXP_W-1:0] le;
  logic              inc;

  always_comb begin
    zero_o = (frac_i == '0);
    hf     = frac_i[TGT:WORD_W];
    rest   = frac_i[WORD_W-1:0];
    lf     = frac_i[WORD_W-1:WORD_W-FRAC_W];
    unique case (mode_i)
      MODE_ROUND: inc = rest[WORD_W-1];
      MODE_TRUNC: inc = neg_i & (|rest);
      default:    inc = 1'b0;
    endcase
    sum = {1'b0, hf} + (FRAC_W+1)'(inc);
    f   = sum[FRAC_W] ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
    e8  = exp_i[EXP_W-1:0] + EXP_W'(sum[FRAC_W]);
    hw  = {1'b0, e8, f};
    if (neg_i) hw = -hw;
    le = exp_i - WEXP_W'(FRAC_W);
    if (le[WEXP_W-1] || lf == '0) lw = '0;
    else                          lw = {1'b0, le[EXP_W-1:0], lf};
    if (neg_i) lw = -lw;
    if (!mode_i[1]) lw = '0;
    if (zero_o) begin
      hw = '0;
      lw = '0;
    end
    hi_o = hw;
    lo_o = lw;
  end
endmodule

// File: rtl/fnr_unit.sv
module fnr_unit
  import fnr_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int EXP_W  = 8,
  parameter int WEXP_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2*WORD_W-1:0] frac_i,
  input  logic [WEXP_W-1:0]   exp_i,
  input  logic [1:0]          mode_i,
  output logic                done_o,
  output logic                zero_o,
  output logic [WORD_W-1:0]   hi_o,
  output logic [WORD_W-1:0]   lo_o
);
  localparam int DW     = 2*WORD_W;
  localparam int FRAC_W = WORD_W-1-EXP_W;
  localparam int TGT    = DW-2-EXP_W;

  fnr_state_e        state_q;
  logic [DW-1:0]     frac_q, st_frac;
  logic [WEXP_W-1:0] exp_q, st_exp;
  logic              neg_q, st_neg, st_fin;
  logic [1:0]        mode_q;
  logic [WORD_W-1:0] pk_hi, pk_lo, hi_q, lo_q, hi_mag;
  logic              pk_zero, zero_q, done_q;

  fnr_step #(.WORD_W(WORD_W), .EXP_W(EXP_W), .WEXP_W(WEXP_W)) step_i (
    .frac_i(frac_q), .exp_i(exp_q), .neg_i(neg_q),
    .frac_o(st_frac), .exp_o(st_exp), .neg_o(st_neg), .fin_o(st_fin)
  );

  fnr_pack #(.WORD_W(WORD_W), .EXP_W(EXP_W), .WEXP_W(WEXP_W)) pack_i (
    .frac_i(frac_q), .exp_i(exp_q), .neg_i(neg_q), .mode_i(mode_q),
    .hi_o(pk_hi), .lo_o(pk_lo), .zero_o(pk_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frac_q  <= '0;
      exp_q   <= '0;
      neg_q   <= 1'b0;
      mode_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          frac_q  <= frac_i;
          exp_q   <= exp_i;
          mode_q  <= mode_i;
          neg_q   <= 1'b0;
          state_q <= ST_NORM;
        end
        ST_NORM: begin
          frac_q <= st_frac;
          exp_q  <= st_exp;
          neg_q  <= st_neg;
          if (st_fin) state_q <= ST_PACK;
        end
        default: begin
          hi_q    <= pk_hi;
          lo_q    <= pk_lo;
          zero_q  <= pk_zero;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign done_o = done_q;
  assign zero_o = zero_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign hi_mag = -hi_q;

  assert_norm_reached_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PACK) |-> (frac_q[DW-1:TGT+1] == '0 && (frac_q[TGT] || frac_q == '0)));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_zero_words_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_o) |-> (hi_o == '0 && lo_o == '0));

  assert_lo_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_q[1]) |-> (lo_o == '0));

  assert_hi_normal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zero_o) |-> (hi_o[WORD_W-1] ? hi_mag[FRAC_W-1] : hi_o[FRAC_W-1]));
endmodule

// File: tb/fnr_unit_tb.sv
module fnr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [71:0] frac_d = '0;
  logic [9:0]  exp_d = '0;
  logic [1:0]  mode_d = '0;
  logic        done, zero;
  logic [35:0] hi, lo;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  fnr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frac_i(frac_d),
    .exp_i(exp_d), .mode_i(mode_d), .done_o(done), .zero_o(zero),
    .hi_o(hi), .lo_o(lo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [71:0] neg72(input logic [71:0] x);
    return ~x + 72'd1;
  endfunction

  // reference: behavioural walk of the requirement rules
  task automatic model(input logic [71:0] fin, input logic [9:0] ein, input logic [1:0] m,
                       output logic [35:0] eh, output logic [35:0] el,
                       output bit ez, output int steps);
    logic [71:0] f = fin;
    int e = int'($signed(ein));
    bit ng = 0;
    int p;
    int sum;
    int le;
    bit inc;
    steps = 0;
    forever begin
      steps++;
      if (f == 0) break;
      if (!ng && f[71]) begin f = neg72(f); ng = 1; continue; end
      if (f[71:36] == 0) begin f = {f[35:0], 36'd0} >> 2; e -= 34; continue; end
      p = 0;
      for (int i = 71; i >= 0; i--) if (f[i]) begin p = i; break; end
      if (p > 62) begin f = f >> 2; e += 2; end
      else if (p == 62) break;
      else if (p >= 59) begin f = f << (62 - p); e -= 62 - p; end
      else begin f = f << 4; e -= 4; end
    end
    ez = (f == 0);
    eh = '0; el = '0;
    if (!ez) begin
      inc = (m == 2'b00) ? f[35] : (m == 2'b01) ? (ng && f[35:0] != 0) : 1'b0;
      sum = int'(f[62:36]) + int'(inc);
      le = e - 27;
      if (sum >= (1 << 27)) begin sum = sum >> 1; e += 1; end
      eh = {1'b0, 8'(e), 27'(sum)};
      if (ng) eh = ~eh + 36'd1;
      if (m[1] && le >= 0 && f[35:9] != 0) begin
        el = {1'b0, 8'(le), f[35:9]};
        if (ng) el = ~el + 36'd1;
      end
    end
  endtask

  task automatic run(input logic [71:0] f, input logic [9:0] e, input logic [1:0] m,
                     input string req, input bit poke);
    logic [35:0] eh, el;
    bit ez;
    int steps;
    bit tok = 1;
    model(f, e, m, eh, el, ez, steps);
    @(negedge clk);
    frac_d = f; exp_d = e; mode_d = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R2: disturb while busy
      frac_d = ~f; exp_d = ~e; mode_d = ~m; start = 1'b1;
    end
    for (int k = 1; k <= steps; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) tok = 0;
    end
    @(negedge clk);
    if (!done) tok = 0;
    check(tok, "R3", {req, " done timing"}, 72'(done), 72'd1);
    check(hi == eh, req, "hi word", 72'(hi), 72'(eh));
    check(lo == el, req, "lo word", 72'(lo), 72'(el));
    check(zero == ez, req, "zero flag", 72'(zero), 72'(ez));
    @(negedge clk);
    check(!done, "R3", "done one cycle", 72'(done), 72'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [71:0] r;
    repeat (3) @(negedge clk);
    check(done == 0 && zero == 0 && hi == 0 && lo == 0, "R1", "reset state",
          {zero, done, hi, lo}, 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run((72'd1 << 62) | (72'h2AAAAAA << 36), 10'd128, 2'b00, "R9", 0);
    run((72'd1 << 61) | 72'h123, 10'd128, 2'b00, "R6", 0);
    run((72'd1 << 60) | (72'h5 << 40), 10'd100, 2'b01, "R6", 0);
    run((72'd1 << 59) | 72'hFFF, 10'd90, 2'b00, "R6", 0);
    run((72'd1 << 40) | 72'h8_0000_0000, 10'd150, 2'b00, "R6", 0);
    run((72'd1 << 70) | 72'h123, 10'd120, 2'b00, "R5", 0);
    run((72'd3 << 63) | (72'd1 << 35), 10'd60, 2'b00, "R5", 0);
    run(72'h1234, 10'd200, 2'b00, "R7", 0);
    run(72'h8_0000_0001, 10'd200, 2'b10, "R7", 0);
    run(72'd0, 10'd77, 2'b00, "R8", 0);
    run(72'd0, 10'd77, 2'b10, "R8", 0);
    run(neg72((72'd1 << 62) | (72'd5 << 40)), 10'd128, 2'b00, "R4", 0);
    run(72'd1 << 71, 10'd128, 2'b00, "R4", 0);
    run(((72'd1 << 28) - 1) << 35, 10'd128, 2'b00, "R10", 0);
    run((72'd1 << 62) | (72'd1 << 34), 10'd128, 2'b00, "R10", 0);
    run(neg72((72'd1 << 62) | 72'd1), 10'd128, 2'b01, "R11", 0);
    run(neg72((72'd1 << 62) | (72'd1 << 36)), 10'd128, 2'b01, "R11", 0);
    run(neg72((((72'd1 << 27) - 1) << 36) | 72'd1), 10'd128, 2'b01, "R11", 0);
    run((72'd1 << 62) | (72'h5 << 10) | (72'd1 << 34), 10'd128, 2'b10, "R12", 0);
    run((72'd1 << 62) | (72'h5 << 20), 10'd20, 2'b10, "R12", 0);
    run((72'd1 << 62) | 72'h1FF, 10'd128, 2'b10, "R12", 0);
    run(neg72((72'd1 << 62) | (72'h7 << 30)), 10'd128, 2'b11, "R12", 0);
    run((72'd1 << 61) | (72'd1 << 35), 10'd128, 2'b00, "R2", 1);
    run(72'h55, 10'd300, 2'b10, "R2", 1);
    for (int i = 0; i < 40; i++) begin
      r = {$urandom, $urandom, $urandom};
      r = r >> ($urandom % 72);
      if ($urandom % 2) r = neg72(r);
      run(r, 10'(120 + ($urandom % 100)), 2'($urandom % 4), "R9", 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule